// File: doc/BRIEF.md
# Overvoltage Clamp and Hiccup Sequencer

This block sequences start-up and fault recovery for a switching regulator controller. A single ramp counter stands in for a soft-start capacitor. It climbs one step per clock while the converter starts. It drains one step per clock after a fault, and the converter may restart only once the ramp has fallen to a low re-enable level. The same counter therefore sets both the start-up time and the retry period when an overload persists.

Three fault flags arrive already compared: a current-limit or short-circuit trip, an overvoltage flag and a reverse-voltage flag. Any of them stops the converter and starts a drain of the ramp. An overvoltage or reverse-voltage event also latches a clamp output. The clamp is released only after the ramp has drained, and only when neither voltage flag is still present. A strap selects latch-off mode, in which a fault stops the converter until enable is dropped or the supply falls into undervoltage.

Top module: `ovclamp_hiccup_seq`

## Requirements
- R1: After reset, `run_o` is 0, `ramp_o` is 0 and `clamp_o` is 0.
- R2: One clock edge after `en_i`=1 with `uv_i`=0 (from off, clamp clear), `run_o` is 1 with `ramp_o`=0. The ramp then rises by exactly one per clock during soft-start, and never moves by more than one step per clock while enabled.
- R3: When the ramp reaches `TERM_LVL`, soft-start ends. The ramp holds at `TERM_LVL`, never exceeds it, and `run_o` stays 1.
- R4: `en_i`=0 or `uv_i`=1 forces, at the next edge, `run_o`=0 and `ramp_o`=0 from any state. `clamp_o` keeps its value while the block is off.
- R5: `ilim_i`, `ov_i` or `rv_i` while running drops `run_o` at the next edge. The ramp then falls by one per clock while it is above `REEN_LVL`.
- R6: Once the ramp is at or below `REEN_LVL`, the converter restarts soft-start at the next edge in which no fault flag is set, continuing up from the current ramp value. While any fault flag stays set, it waits with the ramp held.
- R7: `ov_i` or `rv_i` while the block is enabled and not off sets `clamp_o` at the next edge. `clamp_o` stays 1 after the flag goes away.
- R8: `clamp_o` is cleared only at an edge where the ramp is at or below `REEN_LVL` and both `ov_i` and `rv_i` are 0. After a hiccup with no remaining fault, clamp release and restart happen on the same edge.
- R9: With `latch_off_i`=1, a fault stops the converter permanently. The ramp drains to 0, `run_o` stays 0 until `en_i` is dropped (or `uv_i` is raised) and then restored, and the clamp is still released after the drain.
- R10: Re-enabling with the clamp still latched first spends one cycle draining (`run_o`=0, `clamp_o`=1). Soft-start then begins with the clamp released.
- R11: `clamp_o` and `run_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable, active high |
| uv_i | input | 1 | Supply undervoltage flag, active high |
| ilim_i | input | 1 | Current-limit / short-circuit trip flag |
| ov_i | input | 1 | Overvoltage comparator flag |
| rv_i | input | 1 | Reverse-voltage comparator flag |
| latch_off_i | input | 1 | 1 selects latch-off instead of automatic retry |
| run_o | output | 1 | Converter run enable (soft-start or regulation) |
| ramp_o | output | RAMP_W | Soft-start ramp level |
| clamp_o | output | 1 | Latched protection clamp |

## Verification
Every internal state shows at the ports through the pair `run_o` and `clamp_o` together with the ramp value, and one clock edge is enough to expose it. A wrong state choice after a fault appears as `run_o` staying high, or as a ramp that holds instead of stepping down, at the very next edge. A clamp that is cleared too early shows up as `clamp_o` falling while `ramp_o` is still above the re-enable level. An error in the restart condition shows as `run_o` rising while a fault flag is still set, or failing to rise on the edge after the last flag clears.

// File: rtl/ohs_pkg.sv
package ohs_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_LOCK  = 3'd4
    } ohs_state_e;

    typedef struct packed {
        logic any;   // any fault flag present
        logic ovrv;  // a voltage fault that must latch the clamp
    } ohs_flags_t;

endpackage

// File: rtl/ohs_fault_merge.sv
module ohs_fault_merge
    import ohs_pkg::*;
(
    input  logic       ilim_i,
    input  logic       ov_i,
    input  logic       rv_i,
    output ohs_flags_t flags_o
);

    always_comb begin
        flags_o.ovrv = ov_i | rv_i;
        flags_o.any  = ov_i | rv_i | ilim_i;
    end

endmodule

// File: rtl/ohs_ramp_cmp.sv
module ohs_ramp_cmp #(
    parameter int RAMP_W   = 10,
    parameter int TERM_LVL = 800,
    parameter int REEN_LVL = 80
) (
    input  logic [RAMP_W-1:0] ramp_i,
    output logic              at_top_o,     // next upward step reaches termination
    output logic              above_reen_o, // still above the re-enable level
    output logic              above_zero_o
);

    localparam logic [RAMP_W-1:0] TOP_M1 = RAMP_W'(TERM_LVL - 1);
    localparam logic [RAMP_W-1:0] REEN_V = RAMP_W'(REEN_LVL);

    always_comb begin
        at_top_o     = (ramp_i >= TOP_M1);
        above_reen_o = (ramp_i >  REEN_V);
        above_zero_o = (ramp_i != '0);
    end

endmodule

// File: rtl/ovclamp_hiccup_seq.sv
module ovclamp_hiccup_seq
    import ohs_pkg::*;
#(
    parameter int RAMP_W   = 10,
    parameter int TERM_LVL = 800,
    parameter int REEN_LVL = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uv_i,
    input  logic              ilim_i,
    input  logic              ov_i,
    input  logic              rv_i,
    input  logic              latch_off_i,
    output logic              run_o,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              clamp_o
);

    typedef struct packed {
        ohs_state_e        st;
        logic [RAMP_W-1:0] ramp;
        logic              clamp;
    } seq_t;

    seq_t       cur_q;
    seq_t       nxt_d;
    ohs_flags_t flg;
    logic       at_top;
    logic       above_reen;
    logic       above_zero;

    ohs_fault_merge u_merge (
        .ilim_i  (ilim_i),
        .ov_i    (ov_i),
        .rv_i    (rv_i),
        .flags_o (flg)
    );

    ohs_ramp_cmp #(
        .RAMP_W   (RAMP_W),
        .TERM_LVL (TERM_LVL),
        .REEN_LVL (REEN_LVL)
    ) u_cmp (
        .ramp_i       (cur_q.ramp),
        .at_top_o     (at_top),
        .above_reen_o (above_reen),
        .above_zero_o (above_zero)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!en_i || uv_i) begin
            // power loss: clear all but a latched clamp
            nxt_d.st   = ST_OFF;
            nxt_d.ramp = '0;
        end else begin
            unique case (cur_q.st)
                ST_OFF: begin
                    nxt_d.st = cur_q.clamp ? ST_DRAIN : ST_SOFT;
                end
                ST_SOFT, ST_RUN: begin
                    if (flg.any) begin
                        nxt_d.st    = latch_off_i ? ST_LOCK : ST_DRAIN;
                        nxt_d.clamp = cur_q.clamp | flg.ovrv;
                    end else if (cur_q.st == ST_SOFT) begin
                        nxt_d.ramp = cur_q.ramp + 1'b1;
                        if (at_top) begin
                            nxt_d.st = ST_RUN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (above_reen) begin
                        nxt_d.ramp = cur_q.ramp - 1'b1;
                    end else begin
                        if (!flg.ovrv) begin
                            nxt_d.clamp = 1'b0;
                        end
                        if (!flg.any) begin
                            nxt_d.st = ST_SOFT;
                        end
                    end
                    if (flg.ovrv) begin
                        nxt_d.clamp = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (above_zero) begin
                        nxt_d.ramp = cur_q.ramp - 1'b1;
                    end
                    if (flg.ovrv) begin
                        nxt_d.clamp = 1'b1;
                    end else if (!above_reen) begin
                        nxt_d.clamp = 1'b0;
                    end
                end
                default: begin
                    nxt_d.st = ST_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_OFF, ramp: '0, clamp: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_o   = (cur_q.st == ST_SOFT) || (cur_q.st == ST_RUN);
    assign ramp_o  = cur_q.ramp;
    assign clamp_o = cur_q.clamp;

endmodule

// File: rtl/ohs_seq_chk.sv
module ohs_seq_chk #(
    parameter int RAMP_W   = 10,
    parameter int TERM_LVL = 800,
    parameter int REEN_LVL = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              uv_i,
    input logic              ov_i,
    input logic              rv_i,
    input logic              run_o,
    input logic [RAMP_W-1:0] ramp_o,
    input logic              clamp_o
);

    localparam logic [RAMP_W-1:0] TERM_V = RAMP_W'(TERM_LVL);
    localparam logic [RAMP_W-1:0] REEN_V = RAMP_W'(REEN_LVL);

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || uv_i) |=> (!run_o && ramp_o == '0)); // R4

    AST_CLAMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && en_i && !uv_i && (ov_i || rv_i)) |=> clamp_o); // R7

    AST_CLAMP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_o) |-> (ramp_o <= REEN_V)); // R8

    AST_NO_RUN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_o && run_o)); // R11

    AST_RAMP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_o <= TERM_V); // R3

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !$past(uv_i)) |->
            (({1'b0, ramp_o} == {1'b0, $past(ramp_o)}) ||
             ({1'b0, ramp_o} == {1'b0, $past(ramp_o)} + 1'b1) ||
             ({1'b0, $past(ramp_o)} == {1'b0, ramp_o} + 1'b1))); // R2

endmodule

bind ovclamp_hiccup_seq ohs_seq_chk #(
    .RAMP_W   (RAMP_W),
    .TERM_LVL (TERM_LVL),
    .REEN_LVL (REEN_LVL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .uv_i    (uv_i),
    .ov_i    (ov_i),
    .rv_i    (rv_i),
    .run_o   (run_o),
    .ramp_o  (ramp_o),
    .clamp_o (clamp_o)
);

// File: tb/ovclamp_hiccup_seq_bench.sv
`timescale 1ns/1ps
module ovclamp_hiccup_seq_bench;

    localparam int W    = 6;
    localparam int TERM = 20;
    localparam int REEN = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         uv_i = 1'b0;
    logic         ilim_i = 1'b0;
    logic         ov_i = 1'b0;
    logic         rv_i = 1'b0;
    logic         latch_off_i = 1'b0;
    logic         run_o;
    logic [W-1:0] ramp_o;
    logic         clamp_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    ovclamp_hiccup_seq #(
        .RAMP_W   (W),
        .TERM_LVL (TERM),
        .REEN_LVL (REEN)
    ) u_ovclamp_hiccup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .uv_i        (uv_i),
        .ilim_i      (ilim_i),
        .ov_i        (ov_i),
        .rv_i        (rv_i),
        .latch_off_i (latch_off_i),
        .run_o       (run_o),
        .ramp_o      (ramp_o),
        .clamp_o     (clamp_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        check("R1 run after reset", int'(run_o), 0);
        check("R1 ramp after reset", int'(ramp_o), 0);
        check("R1 clamp after reset", int'(clamp_o), 0);
        rst_n = 1'b1;
        tick(2);
        check("R1 idle while disabled", int'(run_o), 0);
    endtask

    task automatic t_startup();
        en_i = 1'b1;
        tick(1);
        check("R2 run on enable", int'(run_o), 1);
        check("R2 ramp start", int'(ramp_o), 0);
        tick(4);
        check("R2 ramp climbs one per clock", int'(ramp_o), 4);
        tick(16);
        check("R3 ramp at termination", int'(ramp_o), TERM);
        tick(10);
        check("R3 ramp holds", int'(ramp_o), TERM);
        check("R3 stays running", int'(run_o), 1);
    endtask

    task automatic t_hiccup();
        ilim_i = 1'b1;
        tick(1);
        check("R5 run drops on trip", int'(run_o), 0);
        check("R5 ramp at trip", int'(ramp_o), TERM);
        tick(4);
        check("R5 ramp drains", int'(ramp_o), TERM - 4);
        tick(25);
        check("R6 waits at re-enable", int'(ramp_o), REEN);
        check("R6 off while fault held", int'(run_o), 0);
        ilim_i = 1'b0;
        tick(1);
        check("R6 restart after fault clears", int'(run_o), 1);
        check("R6 restart ramp", int'(ramp_o), REEN);
        tick(1);
        check("R6 ramp resumes climbing", int'(ramp_o), REEN + 1);
        tick(20);
        check("R3 back in regulation", int'(ramp_o), TERM);
    endtask

    task automatic t_ovclamp();
        ov_i = 1'b1;
        tick(1);
        check("R7 clamp sets on overvoltage", int'(clamp_o), 1);
        check("R7 run drops", int'(run_o), 0);
        ov_i = 1'b0;
        tick(9);
        check("R7 clamp held after flag clears", int'(clamp_o), 1);
        check("R11 no run while clamped", int'(run_o), 0);
        tick(8);
        check("R8 clamp held until drained", int'(clamp_o), 1);
        check("R8 ramp drained", int'(ramp_o), REEN);
        tick(1);
        check("R8 clamp released", int'(clamp_o), 0);
        check("R8 restart same edge", int'(run_o), 1);
        tick(20);
        check("R3 regulation after clamp", int'(ramp_o), TERM);
    endtask

    task automatic t_rvheld();
        rv_i = 1'b1;
        tick(30);
        check("R8 clamp held while reverse flag", int'(clamp_o), 1);
        check("R6 ramp held at re-enable", int'(ramp_o), REEN);
        rv_i = 1'b0;
        tick(1);
        check("R8 clamp released after reverse flag", int'(clamp_o), 0);
        check("R6 restart after reverse flag", int'(run_o), 1);
        tick(20);
    endtask

    task automatic t_latch();
        latch_off_i = 1'b1;
        ilim_i = 1'b1;
        tick(1);
        ilim_i = 1'b0;
        check("R9 run drops in latch mode", int'(run_o), 0);
        tick(39);
        check("R9 ramp drains to zero", int'(ramp_o), 0);
        check("R9 no restart", int'(run_o), 0);
        tick(20);
        check("R9 still off", int'(run_o), 0);
        rv_i = 1'b1;
        tick(1);
        rv_i = 1'b0;
        check("R7 clamp sets while latched off", int'(clamp_o), 1);
        tick(1);
        check("R8 clamp released when drained", int'(clamp_o), 0);
        en_i = 1'b0;
        tick(1);
        check("R4 off on disable", int'(run_o), 0);
        latch_off_i = 1'b0;
        en_i = 1'b1;
        tick(1);
        check("R9 restart after power cycle", int'(run_o), 1);
        tick(25);
    endtask

    task automatic t_offclamp();
        ov_i = 1'b1;
        tick(1);
        ov_i = 1'b0;
        tick(2);
        en_i = 1'b0;
        tick(1);
        check("R4 run off", int'(run_o), 0);
        check("R4 ramp cleared", int'(ramp_o), 0);
        check("R4 clamp kept", int'(clamp_o), 1);
        tick(5);
        check("R4 clamp kept while off", int'(clamp_o), 1);
        en_i = 1'b1;
        tick(1);
        check("R10 drain cycle first", int'(run_o), 0);
        check("R10 clamp still set", int'(clamp_o), 1);
        tick(1);
        check("R10 clamp released", int'(clamp_o), 0);
        check("R10 soft-start begins", int'(run_o), 1);
        tick(1);
        check("R10 ramp climbing", int'(ramp_o), 1);
        tick(25);
    endtask

    task automatic t_uv();
        check("R3 regulation before undervoltage", int'(ramp_o), TERM);
        uv_i = 1'b1;
        tick(1);
        check("R4 undervoltage stops run", int'(run_o), 0);
        check("R4 undervoltage clears ramp", int'(ramp_o), 0);
        check("R4 clamp unchanged", int'(clamp_o), 0);
        uv_i = 1'b0;
        tick(1);
        check("R2 restart after undervoltage", int'(run_o), 1);
        check("R2 ramp from zero", int'(ramp_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_hiccup();
        t_ovclamp();
        t_rvheld();
        t_latch();
        t_offclamp();
        t_uv();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule